// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer

This block is a unified, fully associative address translation buffer that software fills and inspects through a word-wide register port. Every entry is a pair of 32-bit words, a tag and a data word. Each entry carries its own page-size code, so one entry can map 1 KB while its neighbour maps 16 MB. Instruction fetches and data accesses share the same entries.

A lookup port takes a virtual address and an access kind. In the same cycle it returns hit, physical address, permission fault, zone value and cache attribute bits. A search port reports, one cycle after the request, which entry holds a virtual address. Two invalidation controls drop every entry that matches an address, or drop all entries.

The lookup and search streams are valid-qualified and never back-pressured. The block accepts a request in every cycle, so it has no ready pins. The caller must take the search result in the cycle that `sq_done` is high, because the result is not held. The register port and the invalidation controls are plain strobes.

Top module: `vtlb_unit`

## Requirements
- R1: After reset every entry is invalid and all stored words read as zero; lookups miss, and `sw_rvalid` and `sq_done` are low.
- R2: A write with `sw_sel`=0 stores the tag word of entry `sw_idx` and a write with `sw_sel`=1 stores its data word. A read returns the whole stored word on `sw_rdata` with `sw_rvalid` high in the cycle after `sw_rd`.
- R3: Tag layout: bits 31:10 page number, bits 9:7 size code c (0..7 means 1K, 4K, 16K, 64K, 256K, 1M, 4M, 16M), bit 6 valid. An entry matches when it is valid and virtual address bits 31 down to 10+2c equal the same tag bits.
- R4: On a hit, `lk_pa` takes bits 31 down to 10+2c from the data word's page number (bits 31:10) and keeps the lower bits of the virtual address.
- R5: `lk_acc` encodes 0 read, 1 write, 2 fetch, 3 read. A write hit faults when data bit 8 is clear, and a fetch hit faults when data bit 9 is clear. A read never faults. The fault appears in the same cycle as the hit.
- R6: On a hit, `lk_zone` shows data bits 7:4 and `lk_attr` shows data bits 3:0, in the order write-through, inhibit, coherent, guarded.
- R7: On a miss, or when `lk_valid` is low, hit and fault are low and `lk_pa`, `lk_zone` and `lk_attr` are zero.
- R8: When several entries match, the lowest-numbered one is used by both lookup and search.
- R9: A search request gives `sq_done` high in the next cycle, with `sq_found` and the matching `sq_idx`. When nothing matches, `sq_idx` is zero.
- R10: `inv_one` clears the valid bit (tag bit 6) of every entry that matches `inv_va`, from the next cycle.
- R11: `inv_all` clears every valid bit in one cycle.
- R12: A write in the same cycle as `inv_all` is discarded. A tag write to an entry that `inv_one` would clear in the same cycle takes effect and leaves the entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr | input | 1 | Word write strobe |
| sw_rd | input | 1 | Word read strobe |
| sw_idx | input | IDX_W | Entry index |
| sw_sel | input | 1 | 0 tag word, 1 data word |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data |
| sw_rvalid | output | 1 | Read data valid |
| inv_one | input | 1 | Invalidate entries matching inv_va |
| inv_all | input | 1 | Invalidate all entries |
| inv_va | input | 32 | Address for inv_one |
| lk_valid | input | 1 | Lookup request valid |
| lk_va | input | 32 | Lookup virtual address |
| lk_acc | input | 2 | Access kind |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 32 | Physical address |
| lk_fault | output | 1 | Permission fault |
| lk_zone | output | 4 | Zone select |
| lk_attr | output | 4 | Cache attributes |
| sq_valid | input | 1 | Search request valid |
| sq_va | input | 32 | Search virtual address |
| sq_done | output | 1 | Search result valid |
| sq_found | output | 1 | Search matched |
| sq_idx | output | IDX_W | Matching entry |

## Verification
The bench builds the block with ENTRIES=8. At that size the highest index, 7, can be written and found in a few cycles, and the index width of three bits exercises the encoder's top boundary. The page-size compare does not depend on the entry count, so the 4K and 16M masking cases and the overlap priority cases are as telling at eight entries as at sixty-four.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PAGE_LSB = 10;
  localparam int unsigned PN_W     = WORD_W - PAGE_LSB;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // tag word: page number, size code, valid flag, spare
  typedef struct packed {
    logic [PN_W-1:0] pnum;
    logic [2:0]      size;
    logic            vld;
    logic [5:0]      spare;
  } tag_t;

  // data word: real page number, execute/write permits, zone, attributes
  typedef struct packed {
    logic [PN_W-1:0] rnum;
    logic            can_exec;
    logic            can_write;
    logic [3:0]      zone;
    logic [3:0]      attr;
  } dat_t;

  // ones above the in-page offset of a page with size code c
  function automatic logic [WORD_W-1:0] upper_mask(input logic [2:0] c);
    return {WORD_W{1'b1}} << (PAGE_LSB + 2 * int'(c));
  endfunction

endpackage

// File: rtl/tlb_match_array.sv
module tlb_match_array
  import vtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64
) (
  input  tag_t [ENTRIES-1:0] tags,
  input  logic [WORD_W-1:0]  va,
  output logic [ENTRIES-1:0] hits
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [WORD_W-1:0] msk;
    logic [WORD_W-1:0] diff;
    assign msk     = upper_mask(tags[g].size);
    assign diff    = (va ^ {tags[g].pnum, {PAGE_LSB{1'b0}}}) & msk;
    assign hits[g] = tags[g].vld && (diff == '0);
  end

endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vtlb_unit.sv
module vtlb_unit
  import vtlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic              sw_rd,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              sw_sel,
  input  logic [31:0]       sw_wdata,
  output logic [31:0]       sw_rdata,
  output logic              sw_rvalid,
  input  logic              inv_one,
  input  logic              inv_all,
  input  logic [31:0]       inv_va,
  input  logic              lk_valid,
  input  logic [31:0]       lk_va,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic [31:0]       lk_pa,
  output logic              lk_fault,
  output logic [3:0]        lk_zone,
  output logic [3:0]        lk_attr,
  input  logic              sq_valid,
  input  logic [31:0]       sq_va,
  output logic              sq_done,
  output logic              sq_found,
  output logic [IDX_W-1:0]  sq_idx
);

  tag_t [ENTRIES-1:0] tag_q;
  dat_t [ENTRIES-1:0] dat_q;

  logic [ENTRIES-1:0] lk_hits, sq_hits, inv_hits;
  logic               lk_any, sq_any;
  logic [IDX_W-1:0]   lk_sel, sq_sel;

  tlb_match_array #(.ENTRIES(ENTRIES)) u_lk_match  (.tags(tag_q), .va(lk_va),  .hits(lk_hits));
  tlb_match_array #(.ENTRIES(ENTRIES)) u_sq_match  (.tags(tag_q), .va(sq_va),  .hits(sq_hits));
  tlb_match_array #(.ENTRIES(ENTRIES)) u_inv_match (.tags(tag_q), .va(inv_va), .hits(inv_hits));

  tlb_prio_enc #(.ENTRIES(ENTRIES)) u_lk_enc (.req(lk_hits), .found(lk_any), .idx(lk_sel));
  tlb_prio_enc #(.ENTRIES(ENTRIES)) u_sq_enc (.req(sq_hits), .found(sq_any), .idx(sq_sel));

  // entry storage: flush beats write, tag write beats single invalidate
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_here;
    assign wr_here = sw_wr && !inv_all && (sw_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        dat_q[g] <= '0;
      end else begin
        if (inv_all)                    tag_q[g].vld <= 1'b0;
        else if (wr_here && !sw_sel)    tag_q[g]     <= tag_t'(sw_wdata);
        else if (inv_one && inv_hits[g]) tag_q[g].vld <= 1'b0;
        if (wr_here && sw_sel)          dat_q[g]     <= dat_t'(sw_wdata);
      end
    end
  end

  // register read port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_rvalid <= 1'b0;
      sw_rdata  <= '0;
    end else begin
      sw_rvalid <= sw_rd;
      if (sw_rd) sw_rdata <= sw_sel ? 32'(dat_q[sw_idx]) : 32'(tag_q[sw_idx]);
    end
  end

  // search port, one cycle of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_done  <= 1'b0;
      sq_found <= 1'b0;
      sq_idx   <= '0;
    end else begin
      sq_done  <= sq_valid;
      sq_found <= sq_valid && sq_any;
      sq_idx   <= (sq_valid && sq_any) ? sq_sel : '0;
    end
  end

  // lookup datapath, same cycle
  dat_t        win_dat;
  logic [31:0] win_msk;
  logic        perm_bad;
  acc_e        acc;

  assign acc     = acc_e'(lk_acc);
  assign win_dat = dat_q[lk_sel];
  assign win_msk = upper_mask(tag_q[lk_sel].size);

  always_comb begin
    unique case (acc)
      ACC_WRITE: perm_bad = !win_dat.can_write;
      ACC_FETCH: perm_bad = !win_dat.can_exec;
      default:   perm_bad = 1'b0;
    endcase
  end

  always_comb begin
    lk_hit   = lk_valid && lk_any;
    lk_fault = 1'b0;
    lk_pa    = '0;
    lk_zone  = '0;
    lk_attr  = '0;
    if (lk_hit) begin
      lk_fault = perm_bad;
      lk_pa    = ({win_dat.rnum, {PAGE_LSB{1'b0}}} & win_msk) | (lk_va & ~win_msk);
      lk_zone  = win_dat.zone;
      lk_attr  = win_dat.attr;
    end
  end

  // checks on the block's own behaviour
  p_fault_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);
  p_read_never_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_acc == 2'd0) |-> !lk_fault);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_fault && lk_pa == '0));
  p_search_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> sq_done);
  p_search_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_valid |=> !sq_done);
  p_notfound_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_done && !sq_found) |-> sq_idx == '0);
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd |=> sw_rvalid);
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit);

endmodule

// File: tb/test_vtlb_unit.sv
`timescale 1ns/1ps
module test_vtlb_unit;

  localparam int unsigned N  = 8;
  localparam int unsigned IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_wr = 0, sw_rd = 0, sw_sel = 0;
  logic [IW-1:0] sw_idx = '0;
  logic [31:0] sw_wdata = '0, sw_rdata;
  logic sw_rvalid;
  logic inv_one = 0, inv_all = 0;
  logic [31:0] inv_va = '0;
  logic lk_valid = 0;
  logic [31:0] lk_va = '0, lk_pa;
  logic [1:0] lk_acc = '0;
  logic lk_hit, lk_fault;
  logic [3:0] lk_zone, lk_attr;
  logic sq_valid = 0;
  logic [31:0] sq_va = '0;
  logic sq_done, sq_found;
  logic [IW-1:0] sq_idx;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  vtlb_unit #(.ENTRIES(N)) i_vtlb_unit (
    .clk, .rst_n, .sw_wr, .sw_rd, .sw_idx, .sw_sel, .sw_wdata, .sw_rdata, .sw_rvalid,
    .inv_one, .inv_all, .inv_va, .lk_valid, .lk_va, .lk_acc, .lk_hit, .lk_pa,
    .lk_fault, .lk_zone, .lk_attr, .sq_valid, .sq_va, .sq_done, .sq_found, .sq_idx
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_word(input int idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    sw_wr = 1; sw_idx = IW'(idx); sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_wr = 0;
  endtask

  task automatic rd_word(input string req, input int idx, input logic sel, input logic [31:0] exp);
    @(negedge clk);
    sw_rd = 1; sw_idx = IW'(idx); sw_sel = sel;
    @(negedge clk);
    sw_rd = 0;
    chk(req, "read valid", 32'(sw_rvalid), 32'd1);
    chk(req, "read data", sw_rdata, exp);
  endtask

  task automatic look(input string req, input logic [31:0] va, input logic [1:0] acc,
                      input logic hit, input logic [31:0] pa, input logic flt,
                      input logic [3:0] zn, input logic [3:0] at);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_acc = acc;
    #1;
    chk(req, "hit", 32'(lk_hit), 32'(hit));
    chk(req, "pa", lk_pa, pa);
    chk(req, "fault", 32'(lk_fault), 32'(flt));
    chk(req, "zone", 32'(lk_zone), 32'(zn));
    chk(req, "attr", 32'(lk_attr), 32'(at));
    lk_valid = 0;
  endtask

  task automatic search(input string req, input logic [31:0] va, input logic fnd, input int idx);
    @(negedge clk);
    sq_valid = 1; sq_va = va;
    @(negedge clk);
    sq_valid = 0;
    chk(req, "search done", 32'(sq_done), 32'd1);
    chk(req, "search found", 32'(sq_found), 32'(fnd));
    chk(req, "search index", 32'(sq_idx), 32'(idx));
  endtask

  task automatic kill_one(input logic [31:0] va);
    @(negedge clk);
    inv_one = 1; inv_va = va;
    @(negedge clk);
    inv_one = 0;
  endtask

  // R1: reset state
  task automatic t_reset;
    chk("R1", "search idle", 32'(sq_done), 32'd0);
    chk("R1", "read idle", 32'(sw_rvalid), 32'd0);
    look("R1", 32'h1234_5C7F, 2'd0, 0, 32'h0, 0, 4'h0, 4'h0);
    rd_word("R1", 0, 1'b0, 32'h0);
  endtask

  // R2 R3 R4 R6: small page translation and word readback
  task automatic t_small_page;
    wr_word(0, 1'b0, 32'h1234_5C40);
    wr_word(0, 1'b1, 32'hABCD_E656);
    rd_word("R2", 0, 1'b1, 32'hABCD_E656);
    rd_word("R2", 0, 1'b0, 32'h1234_5C40);
    look("R4", 32'h1234_5C7F, 2'd0, 1, 32'hABCD_E47F, 0, 4'h5, 4'h6);
    look("R3", 32'h1234_587F, 2'd0, 0, 32'h0, 0, 4'h0, 4'h0);
  endtask

  // R3 R4: large and 4K pages mask different bit counts
  task automatic t_big_pages;
    wr_word(1, 1'b0, 32'h5500_03C0);
    wr_word(1, 1'b1, 32'h7700_0100);
    look("R4", 32'h55AB_CDEF, 2'd0, 1, 32'h77AB_CDEF, 0, 4'h0, 4'h0);
    look("R3", 32'h5600_0000, 2'd0, 0, 32'h0, 0, 4'h0, 4'h0);
    wr_word(2, 1'b0, 32'h3000_00C0);
    wr_word(2, 1'b1, 32'h4000_0C00);
    look("R4", 32'h3000_0FFC, 2'd0, 1, 32'h4000_0FFC, 0, 4'h0, 4'h0);
  endtask

  // R5: permission faults per access kind
  task automatic t_perms;
    look("R5", 32'h1234_5C00, 2'd2, 1, 32'hABCD_E400, 0, 4'h5, 4'h6);
    look("R5", 32'h1234_5C00, 2'd1, 1, 32'hABCD_E400, 1, 4'h5, 4'h6);
    look("R5", 32'h5500_0000, 2'd1, 1, 32'h7700_0000, 0, 4'h0, 4'h0);
    look("R5", 32'h5500_0000, 2'd2, 1, 32'h7700_0000, 1, 4'h0, 4'h0);
    look("R5", 32'h5500_0000, 2'd3, 1, 32'h7700_0000, 0, 4'h0, 4'h0);
  endtask

  // R7: miss gives all-zero outputs
  task automatic t_miss;
    look("R7", 32'h9999_9999, 2'd2, 0, 32'h0, 0, 4'h0, 4'h0);
  endtask

  // R8 R9: overlapping entries and search
  task automatic t_overlap;
    wr_word(5, 1'b0, 32'h6000_0040);
    wr_word(5, 1'b1, 32'h1111_1000);
    wr_word(3, 1'b0, 32'h6000_0040);
    wr_word(3, 1'b1, 32'h2222_2000);
    look("R8", 32'h6000_0000, 2'd0, 1, 32'h2222_2000, 0, 4'h0, 4'h0);
    search("R8", 32'h6000_0000, 1, 3);
    search("R9", 32'hDEAD_0000, 0, 0);
    wr_word(7, 1'b0, 32'h7000_0040);
    search("R9", 32'h7000_0123, 1, 7);
  endtask

  // R10: invalidate by address clears every match
  task automatic t_inv_one;
    kill_one(32'h6000_0000);
    rd_word("R10", 3, 1'b0, 32'h6000_0000);
    rd_word("R10", 5, 1'b0, 32'h6000_0000);
    look("R10", 32'h6000_0000, 2'd0, 0, 32'h0, 0, 4'h0, 4'h0);
  endtask

  // R12: tag write beats same-cycle single invalidate
  task automatic t_write_vs_inv;
    @(negedge clk);
    sw_wr = 1; sw_idx = 3'd4; sw_sel = 1'b0; sw_wdata = 32'h6000_0040;
    inv_one = 1; inv_va = 32'h6000_0000;
    @(negedge clk);
    sw_wr = 0; inv_one = 0;
    search("R12", 32'h6000_0000, 1, 4);
  endtask

  // R11 R12: flush in one cycle, concurrent write dropped
  task automatic t_flush;
    @(negedge clk);
    inv_all = 1;
    sw_wr = 1; sw_idx = 3'd6; sw_sel = 1'b0; sw_wdata = 32'h5000_0040;
    @(negedge clk);
    inv_all = 0; sw_wr = 0;
    look("R11", 32'h1234_5C7F, 2'd0, 0, 32'h0, 0, 4'h0, 4'h0);
    look("R11", 32'h7000_0123, 2'd0, 0, 32'h0, 0, 4'h0, 4'h0);
    rd_word("R11", 0, 1'b0, 32'h1234_5C00);
    rd_word("R12", 6, 1'b0, 32'h0);
    search("R11", 32'h6000_0000, 0, 0);
  endtask

  initial begin
    #200_0000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_small_page();
    t_big_pages();
    t_perms();
    t_miss();
    t_overlap();
    t_inv_one();
    t_write_vs_inv();
    t_flush();
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule